// File: doc/BRIEF.md
# SYN character strip filter

This block sits on the character-parallel receive path of a byte-synchronous receiver, after the deserializer. Each received character arrives with a valid strobe and is compared with a programmable SYN value. When stripping is enabled, a run of consecutive SYN characters is handled as a special receive condition. The first SYN of the run is held back and never delivered. The second SYN is delivered together with a one-cycle special-character interrupt. Every later SYN in the same run is removed from the stream. When stripping is disabled, SYN characters are delivered to the host as ordinary data.

In both modes, every SYN received produces a pulse towards the character-synchronisation hunt logic. Any character other than SYN ends the current run and is always delivered. Cycles with the valid strobe low carry no character and leave the run count unchanged. All outputs are registered, so results appear one clock after the input character.

Top module: `syn_strip_filter`

## Requirements
- R1: After reset, out_valid, syn_irq and sync_hit are 0, and out_char is all zeros.
- R2: A valid character that differs from syn_char appears on out_char with out_valid high in the cycle after it is presented, in either mode. It also restarts the SYN run count.
- R3: With strip_en low, every valid SYN character is delivered on out_char with out_valid high one cycle later, and syn_irq stays 0.
- R4: With strip_en high, the first SYN of a run gives out_valid 0 in the following cycle. This holds even when a non-SYN character comes next, so a lone SYN is never delivered.
- R5: With strip_en high, the second consecutive SYN is delivered one cycle later, with syn_irq high for exactly that one cycle.
- R6: With strip_en high, the third and all later consecutive SYNs give out_valid 0 and syn_irq 0.
- R7: sync_hit is high for one cycle after each valid SYN input, whatever the value of strip_en. It is low after any other input cycle.
- R8: A cycle with in_valid low gives out_valid 0 in the next cycle. It does not end or advance a SYN run.
- R9: The SYN value is taken from the syn_char input, so changing syn_char changes which characters are treated as SYN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_char | input | W | Received character |
| in_valid | input | 1 | in_char holds a new character |
| syn_char | input | W | Programmable SYN value |
| strip_en | input | 1 | Enables SYN stripping and the interrupt |
| out_char | output | W | Delivered character |
| out_valid | output | 1 | out_char holds a delivered character |
| syn_irq | output | 1 | Special-character interrupt pulse |
| sync_hit | output | 1 | SYN seen, to the hunt logic |

## Verification
The bench goes after the edges of a SYN run in strip mode.

- A lone SYN followed by data: a design that released the held SYN would show an extra output character.
- Runs of exactly two SYNs and runs of five SYNs: a counter that wrapped instead of saturating would raise a second interrupt or leak a later SYN.
- Idle gaps inside a run: a design that cleared the count on an idle cycle would interrupt on the wrong SYN.
- Strip mode disabled: SYNs must still pass through and still pulse sync_hit, which catches a design that tied the hunt pulse to strip mode.
- A change of syn_char partway through the test: a hard-wired SYN value would misclassify characters after the change.

// File: rtl/syn_strip_filter.sv
module syn_strip_filter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_char,
  input  logic         in_valid,
  input  logic [W-1:0] syn_char,
  input  logic         strip_en,
  output logic [W-1:0] out_char,
  output logic         out_valid,
  output logic         syn_irq,
  output logic         sync_hit
);

  localparam int CW = 2;

  logic [CW-1:0] run_cnt;
  logic          is_syn;
  logic          drop;
  logic          fire;

  assign is_syn = in_valid && (in_char == syn_char);
  assign fire   = is_syn && strip_en && (run_cnt == CW'(1));
  assign drop   = is_syn && strip_en && (run_cnt != CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (in_valid) begin
      if (!is_syn)                 run_cnt <= '0;
      else if (run_cnt != CW'(2))  run_cnt <= run_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_char  <= '0;
      out_valid <= 1'b0;
      syn_irq   <= 1'b0;
      sync_hit  <= 1'b0;
    end else begin
      if (in_valid) out_char <= in_char;
      out_valid <= in_valid && !drop;
      syn_irq   <= fire;
      sync_hit  <= is_syn;
    end
  end

  // R5
  irq_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    syn_irq |-> out_valid && $past(strip_en));

  // R8
  out_needs_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R7
  hit_is_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit |-> $past(in_char) == $past(syn_char));

  // R3
  pass_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !strip_en) |=> out_valid && !syn_irq);

  // R2
  data_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_char != syn_char) |=> out_valid && !sync_hit);

  // R6
  no_double_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    syn_irq |=> !syn_irq);

endmodule

// File: tb/syn_strip_filter_tb.sv
module syn_strip_filter_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] in_char = '0;
  logic         in_valid = 1'b0;
  logic [W-1:0] syn_char = 8'h16;
  logic         strip_en = 1'b0;
  logic [W-1:0] out_char;
  logic         out_valid, syn_irq, sync_hit;

  int checks = 0;
  int failures = 0;
  int run = 0;
  logic [W-1:0] exp_char = '0;
  bit done = 0;

  always #2 clk = ~clk;

  syn_strip_filter #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_char(in_char), .in_valid(in_valid),
    .syn_char(syn_char), .strip_en(strip_en), .out_char(out_char),
    .out_valid(out_valid), .syn_irq(syn_irq), .sync_hit(sync_hit)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [W-1:0] c, input bit s, input string tag);
    bit syn, ev, ei;
    @(negedge clk);
    in_valid = v; in_char = c; strip_en = s;
    syn = v && (c == syn_char);
    ev = v; ei = 0;
    if (v) begin
      if (!syn) run = 0;
      else begin
        run++;
        if (s) begin
          if (run == 2) ei = 1; else ev = 0;
        end
      end
      exp_char = c;
    end
    @(posedge clk); #1;
    chk(tag, "out_valid", out_valid, ev);
    chk(tag, "syn_irq", syn_irq, ei);
    chk(tag, "sync_hit", sync_hit, syn);
    if (ev) chk(tag, "out_char", out_char, exp_char);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "syn_irq", syn_irq, 0);
    chk("R1", "sync_hit", sync_hit, 0);
    chk("R1", "out_char", out_char, 0);
    @(negedge clk); rst_n = 1;

    step(1, 8'h41, 0, "R2");
    step(1, 8'h16, 0, "R3");
    step(1, 8'h16, 0, "R3");
    step(1, 8'h16, 0, "R3");
    step(1, 8'h42, 0, "R2");

    step(1, 8'h16, 1, "R4");
    step(1, 8'h43, 1, "R4");
    step(1, 8'h16, 1, "R4");
    step(1, 8'h16, 1, "R5");
    step(1, 8'h44, 1, "R2");

    step(1, 8'h16, 1, "R4");
    step(1, 8'h16, 1, "R5");
    step(1, 8'h16, 1, "R6");
    step(1, 8'h16, 1, "R6");
    step(1, 8'h16, 1, "R6");
    step(1, 8'h45, 1, "R2");

    step(1, 8'h16, 1, "R4");
    step(0, 8'h16, 1, "R8");
    step(0, 8'h00, 1, "R8");
    step(1, 8'h16, 1, "R5");
    step(0, 8'h99, 1, "R8");
    step(1, 8'h16, 1, "R6");
    step(1, 8'h46, 1, "R2");

    @(negedge clk); syn_char = 8'h7E;
    step(1, 8'h16, 1, "R9");
    step(1, 8'h7E, 1, "R9");
    step(1, 8'h7E, 1, "R9");
    step(1, 8'h7E, 1, "R9");
    step(1, 8'h7E, 0, "R7");
    step(1, 8'h16, 0, "R7");

    for (int i = 0; i < 40; i++)
      step((i % 5) != 0, ((i * 7) % 3 == 0) ? 8'h7E : W'(i), (i / 10) % 2 == 1, "R7");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule